// File: doc/BRIEF.md
# Cell Activity Token Unit with Arbitration Tree

This block keeps one activity bit per cell for a one-dimensional row of identical processing cells. Cell 0 is the leftmost cell and cell N-1 the rightmost. A command broadcast to the whole row is meant to act only in cells whose bit is set, so `tok_en` is exported as the per-cell enable vector. Each clock the controller issues one operation code. The operation can load the bits from a per-cell comparison result or from a per-cell flag, set or clear all of them, move them one cell left or right, or spread them across the cells of one datum.

A log-depth prefix network runs over the current token vector. It reports the leftmost and the rightmost set token as one-hot vectors with valid bits, and it reports whether any token is set at all. A segmented version of the same network, cut at the per-cell datum-start flags, computes the spread result. A datum is a run of adjacent cells that begins at a cell whose start flag is set. Every operation completes in one cycle. The tree outputs are combinational from the registered tokens, so they reflect an operation from the cycle after it is issued.

Top module: `tok_tree_unit`

## Requirements
- R1: While `rst_n` is low, all tokens are 0, `first_oh` and `last_oh` are all zeros, and `first_vld`, `last_vld` and `any_set` are 0.
- R2: With `op_code` = 0 (hold), the tokens keep their value across the clock edge.
- R3: With `op_code` = 1, every token takes the value of its cell's `cmp_hit` bit on that edge.
- R4: With `op_code` = 2, every token becomes 1; with `op_code` = 7, every token becomes 0.
- R5: With `op_code` = 3, every token takes the value of its cell's `flag_in` bit on that edge.
- R6: With `op_code` = 4 (shift left), cell i takes the old token of cell i+1, and cell N-1 takes 0.
- R7: With `op_code` = 5 (shift right), cell i takes the old token of cell i-1, and cell 0 takes 0.
- R8: With `op_code` = 6 (spread), a cell's token becomes 1 if any cell j ≤ i holds a set token with no `dat_start` bit set in cells j+1..i. All other tokens are unchanged, so a set `dat_start` bit stops propagation from the left.
- R9: `first_oh` has exactly one bit set, at the lowest-index set token, when any token is set; `first_vld` is 1 exactly then. With no token set, both are 0.
- R10: `last_oh` has exactly one bit set, at the highest-index set token, when any token is set; `last_vld` is 1 exactly then. With no token set, both are 0.
- R11: `any_set` is the OR of all tokens.
- R12: `tok_en` presents the token register, updated on the clock edge that follows the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 3 | Token operation for this cycle |
| cmp_hit | input | N | Per-cell comparison result |
| flag_in | input | N | Per-cell flag to copy into tokens |
| dat_start | input | N | Per-cell datum-start boundary flags |
| tok_en | output | N | Per-cell enable (token register) |
| first_oh | output | N | One-hot leftmost set token |
| first_vld | output | 1 | A leftmost token exists |
| last_oh | output | N | One-hot rightmost set token |
| last_vld | output | 1 | A rightmost token exists |
| any_set | output | 1 | OR of all tokens |

## Verification
The spread operation is driven with sparse and dense boundary patterns. A single token ahead of a boundary tells a spread that stops at the boundary from one that leaks past it. Boundary flags on the cell that holds the token show whether that cell's own flag is treated as a break. Shifts are applied to vectors with set end cells, which exposes a wrap-around in place of zero fill. Empty, single-bit and full token vectors separate a correct empty-case output and correct one-hot arbitration from a scan that is off by one position.

// File: rtl/tok_pkg.sv
package tok_pkg;
  typedef enum logic [2:0] {
    TOP_HOLD   = 3'd0,
    TOP_CMP    = 3'd1,
    TOP_SETALL = 3'd2,
    TOP_FLAG   = 3'd3,
    TOP_SHL    = 3'd4,
    TOP_SHR    = 3'd5,
    TOP_SPREAD = 3'd6,
    TOP_CLR    = 3'd7
  } tok_op_e;
endpackage

// File: rtl/tok_scan.sv
// Segmented inclusive OR prefix over increasing cell index (log-depth).
module tok_scan #(
  parameter int N = 16
) (
  input  logic [N-1:0] val_i,
  input  logic [N-1:0] seg_i,
  output logic [N-1:0] pre_o
);
  localparam int LV = (N > 1) ? $clog2(N) : 1;

  logic [LV:0][N-1:0] v_lv;
  logic [LV:0][N-1:0] s_lv;

  assign v_lv[0] = val_i;
  assign s_lv[0] = seg_i;

  genvar l, i;
  generate
    for (l = 0; l < LV; l++) begin : g_lvl
      localparam int D = 1 << l;
      for (i = 0; i < N; i++) begin : g_cell
        if (i >= D) begin : g_comb
          assign v_lv[l+1][i] = s_lv[l][i] ? v_lv[l][i] : (v_lv[l][i] | v_lv[l][i-D]);
          assign s_lv[l+1][i] = s_lv[l][i] | s_lv[l][i-D];
        end else begin : g_pass
          assign v_lv[l+1][i] = v_lv[l][i];
          assign s_lv[l+1][i] = s_lv[l][i];
        end
      end
    end
  endgenerate

  assign pre_o = v_lv[LV];
endmodule

// File: rtl/tok_arb.sv
// Leftmost / rightmost / any reduction over the token vector.
module tok_arb #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] tok_i,
  output logic [N-1:0] first_oh,
  output logic         first_vld,
  output logic [N-1:0] last_oh,
  output logic         last_vld,
  output logic         any_o
);
  logic [N-1:0] up_pre;
  logic [N-1:0] tok_rev;
  logic [N-1:0] dn_pre_rev;
  logic [N-1:0] dn_pre;

  tok_scan #(.N(N)) u_up (
    .val_i(tok_i),
    .seg_i('0),
    .pre_o(up_pre)
  );

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_rev
      assign tok_rev[i] = tok_i[N-1-i];
      assign dn_pre[i]  = dn_pre_rev[N-1-i];
    end
  endgenerate

  tok_scan #(.N(N)) u_dn (
    .val_i(tok_rev),
    .seg_i('0),
    .pre_o(dn_pre_rev)
  );

  generate
    for (i = 0; i < N; i++) begin : g_oh
      if (i == 0) begin : g_f0
        assign first_oh[i] = tok_i[i];
      end else begin : g_fn
        assign first_oh[i] = tok_i[i] & ~up_pre[i-1];
      end
      if (i == N-1) begin : g_l0
        assign last_oh[i] = tok_i[i];
      end else begin : g_ln
        assign last_oh[i] = tok_i[i] & ~dn_pre[i+1];
      end
    end
  endgenerate

  assign any_o     = up_pre[N-1];
  assign first_vld = |first_oh;
  assign last_vld  = |last_oh;

  AST_FIRST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(first_oh) && (first_vld == (|tok_i))) else $error("first"); // R9
  AST_LAST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(last_oh) && (last_vld == (|tok_i))) else $error("last"); // R10
  AST_ANY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    any_o == first_vld) else $error("any"); // R11
  AST_FIRST_LE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    first_oh <= last_oh) else $error("order"); // R9
endmodule

// File: rtl/tok_reg.sv
// Token register with next-state selection.
module tok_reg
  import tok_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tok_op_e      op_i,
  input  logic [N-1:0] cmp_hit,
  input  logic [N-1:0] flag_in,
  input  logic [N-1:0] dat_start,
  input  logic [N-1:0] spread_i,
  output logic [N-1:0] tok_q
);
  logic [N-1:0] tok_d;
  logic         tok_ce;

  assign tok_ce = (op_i != TOP_HOLD);

  always_comb begin
    tok_d = tok_q;
    case (op_i)
      TOP_CMP:    tok_d = cmp_hit;
      TOP_SETALL: tok_d = '1;
      TOP_FLAG:   tok_d = flag_in;
      TOP_SHL:    tok_d = {1'b0, tok_q[N-1:1]};
      TOP_SHR:    tok_d = {tok_q[N-2:0], 1'b0};
      TOP_SPREAD: tok_d = spread_i;
      TOP_CLR:    tok_d = '0;
      default:    tok_d = tok_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q <= '0;
    end else if (tok_ce) begin
      tok_q <= tok_d;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == TOP_HOLD |=> $stable(tok_q)) else $error("hold"); // R2
  AST_SETALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == TOP_SETALL |=> &tok_q) else $error("setall"); // R4
  AST_SHL_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == TOP_SHL |=> !tok_q[N-1]) else $error("shl"); // R6
  AST_SHR_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == TOP_SHR |=> !tok_q[0]) else $error("shr"); // R7
  AST_SPREAD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == TOP_SPREAD |=> ((tok_q & $past(tok_q)) == $past(tok_q))) else $error("spread keep"); // R8
  AST_SPREAD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == TOP_SPREAD |=> ((tok_q & $past(dat_start) & ~$past(tok_q)) == '0)) else $error("spread bound"); // R8
endmodule

// File: rtl/tok_tree_unit.sv
module tok_tree_unit
  import tok_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op_code,
  input  logic [N-1:0] cmp_hit,
  input  logic [N-1:0] flag_in,
  input  logic [N-1:0] dat_start,
  output logic [N-1:0] tok_en,
  output logic [N-1:0] first_oh,
  output logic         first_vld,
  output logic [N-1:0] last_oh,
  output logic         last_vld,
  output logic         any_set
);
  tok_op_e      op;
  logic [N-1:0] tok_q;
  logic [N-1:0] spread_v;

  assign op = tok_op_e'(op_code);

  tok_scan #(.N(N)) u_spread (
    .val_i(tok_q),
    .seg_i(dat_start),
    .pre_o(spread_v)
  );

  tok_reg #(.N(N)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op),
    .cmp_hit  (cmp_hit),
    .flag_in  (flag_in),
    .dat_start(dat_start),
    .spread_i (spread_v),
    .tok_q    (tok_q)
  );

  tok_arb #(.N(N)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .tok_i    (tok_q),
    .first_oh (first_oh),
    .first_vld(first_vld),
    .last_oh  (last_oh),
    .last_vld (last_vld),
    .any_o    (any_set)
  );

  assign tok_en = tok_q;

  AST_LOAD_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    op == TOP_CMP |=> tok_en == $past(cmp_hit)) else $error("cmp"); // R3
  AST_LOAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    op == TOP_FLAG |=> tok_en == $past(flag_in)) else $error("flag"); // R5
endmodule

// File: tb/tok_tree_unit_test.sv
module tok_tree_unit_test;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [2:0]   op_code;
  logic [N-1:0] cmp_hit, flag_in, dat_start;
  logic [N-1:0] tok_en, first_oh, last_oh;
  logic         first_vld, last_vld, any_set;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [N-1:0] mdl;

  always #2 clk = ~clk;

  tok_tree_unit #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .cmp_hit(cmp_hit),
    .flag_in(flag_in), .dat_start(dat_start), .tok_en(tok_en),
    .first_oh(first_oh), .first_vld(first_vld), .last_oh(last_oh),
    .last_vld(last_vld), .any_set(any_set)
  );

  function automatic logic [N-1:0] f_spread(logic [N-1:0] t, logic [N-1:0] s);
    logic [N-1:0] r;
    logic carry;
    carry = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (s[i]) carry = 1'b0;
      carry = carry | t[i];
      r[i] = carry;
    end
    return r;
  endfunction

  function automatic logic [N-1:0] f_first(logic [N-1:0] t);
    for (int i = 0; i < N; i++) if (t[i]) return N'(1) << i;
    return '0;
  endfunction

  function automatic logic [N-1:0] f_last(logic [N-1:0] t);
    for (int i = N-1; i >= 0; i--) if (t[i]) return N'(1) << i;
    return '0;
  endfunction

  function automatic logic [N-1:0] f_next(logic [2:0] op, logic [N-1:0] t,
      logic [N-1:0] c, logic [N-1:0] f, logic [N-1:0] s);
    case (op)
      3'd1: return c;
      3'd2: return '1;
      3'd3: return f;
      3'd4: return t >> 1;
      3'd5: return t << 1;
      3'd6: return f_spread(t, s);
      3'd7: return '0;
      default: return t;
    endcase
  endfunction

  function automatic string f_tag(logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic chk_outputs(string tag);
    chk({tag, "/R12 tok_en"}, tok_en, mdl);
    chk("R9 first_oh", first_oh, f_first(mdl));
    chk("R9 first_vld", N'(first_vld), N'(|mdl));
    chk("R10 last_oh", last_oh, f_last(mdl));
    chk("R10 last_vld", N'(last_vld), N'(|mdl));
    chk("R11 any_set", N'(any_set), N'(|mdl));
  endtask

  task automatic step(logic [2:0] op, logic [N-1:0] c, logic [N-1:0] f, logic [N-1:0] s);
    @(negedge clk);
    op_code = op; cmp_hit = c; flag_in = f; dat_start = s;
    mdl = f_next(op, mdl, c, f, s);
    @(posedge clk);
    #1;
    chk_outputs(f_tag(op));
  endtask

  initial begin
    rst_n = 1'b0;
    op_code = 3'd2; cmp_hit = '1; flag_in = '1; dat_start = '0;
    mdl = '0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk_outputs("R1");
    @(negedge clk);
    op_code = 3'd0;
    rst_n = 1'b1;

    // Directed corner cases
    step(3'd7, '0, '0, '0);                        // R4 clear, empty outputs R9/R10
    step(3'd6, '0, '0, 16'h0101);                  // R8 spread with nothing set
    step(3'd1, 16'h0004, '0, '0);                  // R3 single token
    step(3'd6, '0, '0, 16'h0040);                  // R8 stops at cell 6
    step(3'd3, '0, 16'h8001, '0);                  // R5 both end cells
    step(3'd4, '0, '0, '0);                        // R6 drop cell 0, zero fill at top
    step(3'd5, '0, '0, '0);                        // R7 zero fill at cell 0
    step(3'd3, '0, 16'h8000, '0);
    step(3'd5, '0, '0, '0);                        // R7 top bit falls off
    step(3'd1, 16'h0010, '0, 16'h0010);
    step(3'd6, '0, '0, 16'h0110);                  // R8 own flag does not block
    step(3'd2, '0, '0, '0);                        // R4 all set
    step(3'd0, 16'h1234, 16'h5678, 16'hffff);      // R2 hold ignores inputs
    step(3'd4, '0, '0, '0);                        // R6 from full

    // Constrained random mix
    for (int k = 0; k < 3000; k++) begin
      logic [2:0] op;
      logic [N-1:0] c, f, s;
      op = 3'($urandom_range(0, 7));
      c  = N'($urandom & $urandom & $urandom);
      f  = N'($urandom & $urandom);
      s  = N'($urandom & $urandom);
      if (op == 3'd2 && ($urandom_range(0, 3) != 0)) op = 3'd6;
      step(op, c, f, s);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule